// File: doc/BRIEF.md
# Dual Clock-Source Select Sequencer

This block owns two 3-bit clock-source select fields, one for each display channel, and changes them without letting a glitch reach the clock divider that follows the select mux. Each field controls a two-level mux. Bits [1:0] steer two 4-input muxes at once. Bit 2 steers a final 2-input mux that picks between the upper group (codes 0 to 3) and the lower group (codes 4 to 7). Code 4 is the one real source in the lower group. Codes 5, 6 and 7 are unconnected. A field leaves reset at code 3.

A one-cycle `start` samples the requested codes, the hold time and a flag that says whether the code-2 source currently clocks the memory. Each channel is planned on its own: it is skipped, refused, or moved. If at least one channel moves, the block asks for the parent clocks to be gated and waits for the acknowledge. It then writes both fields together three times: first it parks in the lower group, then it sets the low bits while parked there, then it returns to the final code. Each write is held for a programmable time. After the last hold the block releases the gate request, waits for the acknowledge to drop, and pulses `done`. Per-channel skipped, refused and moved-from-reset flags are valid from `done` onwards.

All pins are plain control and status signals. Nothing streams through the block, so there is no valid/ready pair and no back-pressure. A request is accepted only while `busy` is low.

Top module: `dual_clksel_sequencer`

## Requirements
- R1: After reset both fields hold code 3 (`sel_out` = 6'o33), and `busy`, `done`, `gate_req` and `sel_wr` are all low.
- R2: A channel whose requested code equals its present code sets its `skipped` bit and keeps its field unchanged for the whole sequence.
- R3: A moving channel's field takes, in order, the present code, present OR 4, requested OR 4, and the requested code. Each new value appears together with a one-cycle `sel_wr`, and there are exactly three writes.
- R4: Both fields (channel 0 in bits [2:0], channel 1 in bits [5:3]) are updated by the same write. A channel that does not move repeats its value on every write.
- R5: Bits [1:0] of a field change only in a cycle where bit 2 is 1 both before and after the change.
- R6: When any channel moves, `gate_req` rises one cycle after `start` is sampled. No write happens unless `gate_ack` was high at that edge. `gate_req` falls exactly `hold_cycles`+1 cycles after the last write. `done` follows only after `gate_ack` has dropped.
- R7: If no channel moves, there are no writes and `gate_req` never rises, and `done` is high in the second cycle after the `start` cycle.
- R8: With `mem_on_shared` = 1, a change from or to code 2 sets that channel's `refused` bit and leaves its field unchanged.
- R9: A requested code of 5, 6 or 7 sets that channel's `refused` bit and leaves its field unchanged.
- R10: A channel's `warn_moved` bit is set when its field is not 3 at the accepted `start`.
- R11: Each written code is held for `hold_cycles`+1 cycles before the next write, using the `hold_cycles` value sampled at `start`.
- R12: `busy` is high from the cycle after `start` until `done`. `done` is a one-cycle pulse. A `start` while `busy` is high has no effect on the writes or the final codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| req_sel | input | 6 | Requested codes, channel c in bits [3c+2:3c] |
| mem_on_shared | input | 1 | Code-2 source is in use as the memory clock |
| hold_cycles | input | 8 | Extra hold cycles per written code |
| gate_ack | input | 1 | Parent clocks are gated |
| sel_out | output | 6 | Live select fields |
| sel_wr | output | 1 | One-cycle strobe marking a field write |
| gate_req | output | 1 | Request to gate the parent clocks |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| skipped | output | 2 | Channel left as is because request equals present code |
| refused | output | 2 | Channel change refused |
| warn_moved | output | 2 | Field was not at its reset code at start |

## Verification
Every result has a fixed distance from its cause. `busy` is due one cycle after the `start` edge. For a request with no moving channel, `done` is due two cycles after it. The first write lands at the edge where an acknowledge is seen. The following writes are due `hold_cycles`+1 cycles apart, and `gate_req` falls the same distance after the third write. The bench drives inputs on the falling edge and samples there, so each value it reads is the one registered at the edge just passed. It records the cycle index of every strobe and of the gate release and compares those indices arithmetically. The acknowledge model changes 1 ns after a falling edge, so the bench always reads the same acknowledge value that the design sampled.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] CODE_RESET   = 3'd3;
  localparam logic [SEL_W-1:0] CODE_SHARED  = 3'd2;
  localparam logic [SEL_W-1:0] CODE_LAST_OK = 3'd4;
  localparam logic [SEL_W-1:0] GROUP_MASK   = 3'b100;
  localparam int N_WRITES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE,
    ST_STEP,
    ST_UNGATE,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/clksel_step_plan.sv
module clksel_step_plan
  import clksel_pkg::*;
(
  input  logic [SEL_W-1:0] cur,
  input  logic [SEL_W-1:0] req,
  input  logic             shared_busy,
  output logic [SEL_W-1:0] step1,
  output logic [SEL_W-1:0] step2,
  output logic [SEL_W-1:0] step3,
  output logic             change,
  output logic             skip,
  output logic             err,
  output logic             warn
);
  logic same, bad_code, shared_hit;

  always_comb begin
    same       = (cur == req);
    bad_code   = (req > CODE_LAST_OK);
    shared_hit = shared_busy && ((cur == CODE_SHARED) || (req == CODE_SHARED));
    skip       = same;
    err        = !same && (bad_code || shared_hit);
    change     = !same && !err;
    warn       = (cur != CODE_RESET);
    // park low group, retarget low bits there, then return
    step1 = change ? (cur | GROUP_MASK) : cur;
    step2 = change ? (req | GROUP_MASK) : cur;
    step3 = change ? req : cur;
  end
endmodule

// File: rtl/clksel_hold_timer.sv
module clksel_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  assert_reload_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/dual_clksel_sequencer.sv
module dual_clksel_sequencer
  import clksel_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int HOLD_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NCH*SEL_W-1:0]  req_sel,
  input  logic                  mem_on_shared,
  input  logic [HOLD_W-1:0]     hold_cycles,
  input  logic                  gate_ack,
  output logic [NCH*SEL_W-1:0]  sel_out,
  output logic                  sel_wr,
  output logic                  gate_req,
  output logic                  busy,
  output logic                  done,
  output logic [NCH-1:0]        skipped,
  output logic [NCH-1:0]        refused,
  output logic [NCH-1:0]        warn_moved
);
  localparam int FW = NCH * SEL_W;
  localparam logic [1:0] LAST_STEP = 2'(N_WRITES);

  seq_state_t state_q;
  logic [FW-1:0] sel_q, s1_w, s2_w, s3_w, s1_q, s2_q, s3_q, next_code;
  logic [NCH-1:0] chg_w, skip_w, err_w, warn_w, skip_q, err_q, warn_q;
  logic [HOLD_W-1:0] hold_q;
  logic [1:0] step_q;
  logic wr_q, done_q, tmr_load, tmr_exp;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int LSB = c * SEL_W;
    clksel_step_plan u_plan (
      .cur         (sel_q[LSB +: SEL_W]),
      .req         (req_sel[LSB +: SEL_W]),
      .shared_busy (mem_on_shared),
      .step1       (s1_w[LSB +: SEL_W]),
      .step2       (s2_w[LSB +: SEL_W]),
      .step3       (s3_w[LSB +: SEL_W]),
      .change      (chg_w[c]),
      .skip        (skip_w[c]),
      .err         (err_w[c]),
      .warn        (warn_w[c])
    );

    // R5: low bits move only while parked in the lower group
    assert_park_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[LSB +: 2] != $past(sel_q[LSB +: 2])) |->
        (sel_q[LSB + 2] && $past(sel_q[LSB + 2])));
    assert_skip_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_IDLE) && skip_q[c]) |=> $stable(sel_q[LSB +: SEL_W]));
    assert_refuse_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_IDLE) && err_q[c]) |=> $stable(sel_q[LSB +: SEL_W]));
  end

  clksel_hold_timer #(.W(HOLD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (hold_q),
    .expired  (tmr_exp)
  );

  always_comb begin
    tmr_load = 1'b0;
    if (state_q == ST_GATE && gate_ack) tmr_load = 1'b1;
    if (state_q == ST_STEP && tmr_exp && step_q != LAST_STEP) tmr_load = 1'b1;
    if (state_q == ST_GATE)   next_code = s1_q;
    else if (step_q == 2'd1)  next_code = s2_q;
    else                      next_code = s3_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= {NCH{CODE_RESET}};
      s1_q    <= '0;
      s2_q    <= '0;
      s3_q    <= '0;
      skip_q  <= '0;
      err_q   <= '0;
      warn_q  <= '0;
      hold_q  <= '0;
      step_q  <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          s1_q    <= s1_w;
          s2_q    <= s2_w;
          s3_q    <= s3_w;
          skip_q  <= skip_w;
          err_q   <= err_w;
          warn_q  <= warn_w;
          hold_q  <= hold_cycles;
          step_q  <= '0;
          state_q <= (|chg_w) ? ST_GATE : ST_FIN;
        end
        ST_GATE: if (gate_ack) begin
          sel_q   <= next_code;
          wr_q    <= 1'b1;
          step_q  <= 2'd1;
          state_q <= ST_STEP;
        end
        ST_STEP: if (tmr_exp) begin
          if (step_q == LAST_STEP) begin
            state_q <= ST_UNGATE;
          end else begin
            sel_q  <= next_code;
            wr_q   <= 1'b1;
            step_q <= step_q + 2'd1;
          end
        end
        ST_UNGATE: if (!gate_ack) state_q <= ST_FIN;
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_out    = sel_q;
  assign sel_wr     = wr_q;
  assign gate_req   = (state_q == ST_GATE) || (state_q == ST_STEP);
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign skipped    = skip_q;
  assign refused    = err_q;
  assign warn_moved = warn_q;

  assert_write_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (gate_req && $past(gate_ack)));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sel_q));
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);
endmodule

// File: tb/dual_clksel_sequencer_tb.sv
module dual_clksel_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] req_sel = '0;
  logic mem_on_shared = 1'b0;
  logic [7:0] hold_cycles = '0;
  logic gate_ack = 1'b0;
  logic [5:0] sel_out;
  logic sel_wr, gate_req, busy, done;
  logic [1:0] skipped, refused, warn_moved;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [2:0] model [2];

  always #2 clk = ~clk;

  dual_clksel_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_sel(req_sel),
    .mem_on_shared(mem_on_shared), .hold_cycles(hold_cycles),
    .gate_ack(gate_ack), .sel_out(sel_out), .sel_wr(sel_wr),
    .gate_req(gate_req), .busy(busy), .done(done), .skipped(skipped),
    .refused(refused), .warn_moved(warn_moved)
  );

  // acknowledge follows gate_req two falling edges later, changed 1 ns after the edge
  initial begin
    logic ack_d;
    ack_d = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      gate_ack = ack_d;
      ack_d = gate_req;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [2:0] r0, input logic [2:0] r1, input logic m,
                          input int h, input bit poke);
    logic [2:0] cur [2], rq [2], e1 [2], e2 [2], e3 [2];
    logic [1:0] chg, er, sk, wn;
    logic [5:0] prev;
    int wcyc [3];
    int nwr, cyc, fall, dcyc;
    bit gseen, gprev, any;
    rq[0] = r0; rq[1] = r1;
    for (int c = 0; c < 2; c++) begin
      cur[c] = model[c];
      sk[c] = (cur[c] == rq[c]);
      er[c] = !sk[c] && ((rq[c] > 3'd4) || (m && (cur[c] == 3'd2 || rq[c] == 3'd2)));
      chg[c] = !sk[c] && !er[c];
      wn[c] = (cur[c] != 3'd3);
      e1[c] = chg[c] ? (cur[c] | 3'd4) : cur[c];
      e2[c] = chg[c] ? (rq[c] | 3'd4) : cur[c];
      e3[c] = chg[c] ? rq[c] : cur[c];
    end
    any = |chg;
    req_sel = {r1, r0};
    mem_on_shared = m;
    hold_cycles = 8'(h);
    start = 1'b1;
    prev = sel_out;
    nwr = 0; cyc = 0; fall = -1; dcyc = -1; gseen = 0; gprev = 0;
    while (dcyc < 0 && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        start = 1'b0;
        chk(busy == 1'b1, "R12 busy after start", busy, 1);
      end
      if (poke && cyc == 3) begin start = 1'b1; req_sel = 6'o00; mem_on_shared = 1'b0; end
      if (poke && cyc == 4) start = 1'b0;
      for (int c = 0; c < 2; c++)
        if (sel_out[3*c +: 2] != prev[3*c +: 2])
          chk(sel_out[3*c+2] && prev[3*c+2], "R5 low bits moved outside lower group",
              sel_out, prev);
      if (sel_wr) begin
        logic [5:0] ev;
        ev = (nwr == 0) ? {e1[1], e1[0]} : (nwr == 1) ? {e2[1], e2[0]} : {e3[1], e3[0]};
        if (nwr < 3) wcyc[nwr] = cyc;
        chk(sel_out == ev, "R3 R4 write value", sel_out, ev);
        chk(gate_req && gate_ack, "R6 write while gated", {gate_req, gate_ack}, 2'b11);
        nwr++;
      end else begin
        chk(sel_out == prev, "R3 field changed without strobe", sel_out, prev);
      end
      if (gate_req) gseen = 1;
      if (gprev && !gate_req && fall < 0) fall = cyc;
      gprev = gate_req;
      if (done) dcyc = cyc;
      prev = sel_out;
    end
    chk(dcyc > 0, "R12 done seen", dcyc, 1);
    chk(busy == 1'b0, "R12 busy low at done", busy, 0);
    if (!any) begin
      chk(nwr == 0, "R7 no writes", nwr, 0);
      chk(!gseen, "R7 no gate request", gseen, 0);
      chk(dcyc == 2, "R7 done timing", dcyc, 2);
    end else begin
      chk(nwr == 3, "R3 three writes", nwr, 3);
      if (nwr == 3) begin
        chk(wcyc[1] - wcyc[0] == h + 1, "R11 hold of first code", wcyc[1] - wcyc[0], h + 1);
        chk(wcyc[2] - wcyc[1] == h + 1, "R11 hold of second code", wcyc[2] - wcyc[1], h + 1);
        chk(fall == wcyc[2] + h + 1, "R6 gate release timing", fall, wcyc[2] + h + 1);
      end
      chk(gate_ack == 1'b0, "R6 done after ack dropped", gate_ack, 0);
    end
    chk(skipped == sk, "R2 skipped flags", skipped, sk);
    chk(refused == er, "R8 R9 refused flags", refused, er);
    chk(warn_moved == wn, "R10 warn flags", warn_moved, wn);
    chk(sel_out == {e3[1], e3[0]}, "R4 final codes", sel_out, {e3[1], e3[0]});
    @(negedge clk);
    chk(done == 1'b0, "R12 done one cycle", done, 0);
    model[0] = e3[0];
    model[1] = e3[1];
    // let the acknowledge settle low before the next request
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model[0] = 3'd3;
    model[1] = 3'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_out == 6'o33, "R1 reset codes", sel_out, 6'o33);
    chk({busy, done, gate_req, sel_wr} == 4'b0, "R1 reset status",
        {busy, done, gate_req, sel_wr}, 0);
    // no-change request first: nothing moves, no warning
    run_case(3'd3, 3'd3, 1'b0, 1, 0);
    for (int h = 0; h <= 2; h += 2)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 5; p++)
          for (int r = 0; r < 8; r++) begin
            run_case(3'(p), 3'((p + 1) % 5), 1'b0, 0, 0);
            run_case(3'(r), 3'((r + 3) % 8), 1'(m), h, 0);
          end
    // R12: a second start while busy is ignored
    run_case(3'd3, 3'd3, 1'b0, 0, 0);
    run_case(3'd1, 3'd4, 1'b0, 3, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule